// File: doc/BRIEF.md
# Single/Double Precision Readout Expander

This block sits between a local store of accumulated 16-bit signed words and a host buffer that is reached one word at a time. A neighbouring DMA engine owns the bus and host addressing. It hands this block one host word per strobe and takes back one result word a cycle later. The block supplies the local side: it reads the word at its own address counter and forms the result. It writes the local word back or clears it, and it advances the counter.

In accumulate mode each local word can be widened to a 32-bit signed value and added into host memory as two 16-bit halves. The low-half carry and the local sign are saved between the halves. The upper operand is all ones or all zeros depending on the saved sign. The local word is cleared once the upper half has been produced. A single-precision option adds one 16-bit word, truncates the sum and clears the local word.

Two other modes exist. A plain readout returns local words and can optionally clear them. A host-to-local write either overwrites local words or adds into them. A restart pulse returns the counter and the half-word phase to their start. An erase command zeroes the whole store without host involvement.

Top module: `rx_expander`

## Requirements
- R1: After reset, result_valid and erase_busy are 0, local_addr is 0, and every local word reads as 0.
- R2: An accepted host_valid strobe produces result_valid high for exactly the next cycle, carrying result_data. A strobe is accepted when erase_busy, erase_go and restart are all low.
- R3: Write mode (cfg_mode 01) with cfg_destr=1 replaces the local word with host_data. It returns the new value and advances local_addr.
- R4: Write mode with cfg_destr=0 stores host_data plus the local word, modulo 2^16. It returns that sum and advances local_addr.
- R5: Readout mode (cfg_mode 00, and 11) returns the local word unchanged and advances local_addr. With cfg_destr=1 it then clears the word; with cfg_destr=0 the store is left as it was.
- R6: Accumulate mode (cfg_mode 10) with cfg_single=1 returns host_data plus the local word, truncated to 16 bits with no overflow correction. It clears the local word and advances local_addr on every word.
- R7: Accumulate with cfg_single=0, first (low) half: returns host_data plus the local word modulo 2^16. It saves that addition's carry-out and the local word's bit 15, and leaves local_addr unchanged.
- R8: Accumulate with cfg_single=0, second (high) half: returns host_data + (0xFFFF if the saved bit 15 was 1, else 0) + saved carry, modulo 2^16. It then clears the local word and advances local_addr. The two results together equal the 32-bit host value plus the sign-extended local word.
- R9: The half-word phase toggles only on accepted double-precision accumulate words and holds in every other mode. A restart pulse sets both local_addr and the phase to zero.
- R10: erase_go sets local_addr to 0 and raises erase_busy. The block then zeroes one word per cycle, advancing local_addr after each write. erase_busy drops after DEPTH cycles, when the address wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 00 readout, 01 host write, 10 accumulate, 11 readout |
| cfg_single | input | 1 | Single precision (1) or double precision (0) accumulate |
| cfg_destr | input | 1 | Destructive option: clear on readout, overwrite on write |
| restart | input | 1 | Zero local address and half-word phase |
| erase_go | input | 1 | Start a full erase of the local store |
| host_valid | input | 1 | One-cycle strobe: host word present |
| host_data | input | W | Host word |
| result_valid | output | 1 | One-cycle strobe: result word present |
| result_data | output | W | Result word to the host |
| local_addr | output | AW | Current local word address |
| erase_busy | output | 1 | Erase in progress |

## Verification
The assertions assume that cfg_mode, cfg_single and cfg_destr stay constant across the two halves of a double-precision pair. They also assume that the neighbouring engine issues host_valid only as isolated one-cycle strobes, never while an erase is running. The stimulus changes mode bits only after a restart and with host_valid low. It spaces every strobe by an idle cycle and waits for erase_busy to fall before issuing further words. The reference model computes the 32-bit sum from the sign-extended local word independently. Its vectors include negative local words, a low-half carry into the upper half and a wrap of the 32-bit total.

// File: rtl/rx_pkg.sv
package rx_pkg;
   typedef enum logic [1:0] {
      XM_READ  = 2'b00,
      XM_WRITE = 2'b01,
      XM_ACCUM = 2'b10,
      XM_SPARE = 2'b11
   } xmode_e;
endpackage

// File: rtl/rx_alu.sv
module rx_alu
   import rx_pkg::*;
#(
   parameter int W = 16
) (
   input  xmode_e       mode,
   input  logic         single,
   input  logic         destr,
   input  logic         hi_phase,
   input  logic         sign_q,
   input  logic         carry_q,
   input  logic [W-1:0] host,
   input  logic [W-1:0] local_word,
   output logic [W-1:0] res,
   output logic [W-1:0] wdata,
   output logic         wr,
   output logic         adv,
   output logic         lo_cout
);
   logic [W:0]   sum_lo;
   logic [W-1:0] sum_hi;
   logic [W-1:0] ext_word;

   always_comb begin
      sum_lo   = {1'b0, host} + {1'b0, local_word};
      ext_word = {W{sign_q}};
      sum_hi   = host + ext_word + {{(W-1){1'b0}}, carry_q};
      lo_cout  = sum_lo[W];
      res      = local_word;
      wdata    = '0;
      wr       = 1'b0;
      adv      = 1'b1;
      case (mode)
         XM_WRITE: begin
            wr    = 1'b1;
            wdata = destr ? host : sum_lo[W-1:0];
            res   = wdata;
         end
         XM_ACCUM: begin
            if (single) begin
               res = sum_lo[W-1:0];
               wr  = 1'b1;
            end else if (!hi_phase) begin
               res = sum_lo[W-1:0];
               adv = 1'b0;
            end else begin
               res = sum_hi;
               wr  = 1'b1;
            end
         end
         default: begin
            res = local_word;
            wr  = destr;
         end
      endcase
   end
endmodule

// File: rtl/rx_store.sv
module rx_store #(
   parameter int W              = 16,
   parameter int DEPTH          = 64,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words[i] <= '0;
            else if (we && addr == AW'(i))
               words[i] <= wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we && addr == AW'(i))
               words[i] <= wdata;
         end
      end
   end

   assign rdata = words[addr];
endmodule

// File: rtl/rx_seq.sv
module rx_seq
   import rx_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  xmode_e        mode,
   input  logic          single,
   input  logic          restart,
   input  logic          erase_go,
   input  logic          host_valid,
   input  logic [W-1:0]  alu_res,
   input  logic          alu_adv,
   input  logic          lo_cout,
   input  logic          local_sign,
   output logic          accept,
   output logic [AW-1:0] addr,
   output logic          erase_busy,
   output logic          result_valid,
   output logic [W-1:0]  result_data,
   output logic          hi_phase,
   output logic          sign_q,
   output logic          carry_q
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   logic dbl_acc;

   assign dbl_acc = (mode == XM_ACCUM) && !single;
   assign accept  = host_valid && !erase_busy && !erase_go && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr         <= '0;
         erase_busy   <= 1'b0;
         result_valid <= 1'b0;
         result_data  <= '0;
         hi_phase     <= 1'b0;
         sign_q       <= 1'b0;
         carry_q      <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         if (erase_go) begin
            erase_busy <= 1'b1;
            addr       <= '0;
         end else if (erase_busy) begin
            addr <= addr + 1'b1;
            if (addr == LAST)
               erase_busy <= 1'b0;
         end else if (restart) begin
            addr     <= '0;
            hi_phase <= 1'b0;
         end else if (host_valid) begin
            result_valid <= 1'b1;
            result_data  <= alu_res;
            if (alu_adv)
               addr <= addr + 1'b1;
            if (dbl_acc) begin
               hi_phase <= ~hi_phase;
               if (!hi_phase) begin
                  sign_q  <= local_sign;
                  carry_q <= lo_cout;
               end
            end
         end
      end
   end

   assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> result_valid);
   assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !result_valid);
   assert_phase_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !(accept && dbl_acc)) |=> $stable(hi_phase));
   assert_low_half_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dbl_acc && !hi_phase) |=> $stable(addr));
   assert_high_half_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dbl_acc && hi_phase) |=> (addr == AW'($past(addr) + 1'b1)));
   assert_erase_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_busy && !erase_go) |=> (addr == AW'($past(addr) + 1'b1)));
   assert_erase_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_busy && !erase_go && addr == LAST) |=> !erase_busy);
endmodule

// File: rtl/rx_expander.sv
module rx_expander
   import rx_pkg::*;
#(
   parameter int W              = 16,
   parameter int DEPTH          = 64,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_mode,
   input  logic          cfg_single,
   input  logic          cfg_destr,
   input  logic          restart,
   input  logic          erase_go,
   input  logic          host_valid,
   input  logic [W-1:0]  host_data,
   output logic          result_valid,
   output logic [W-1:0]  result_data,
   output logic [AW-1:0] local_addr,
   output logic          erase_busy
);
   initial begin
      assert_width_ok: assert (W >= 2);
      assert_depth_pow2: assert (DEPTH >= 2 && (1 << AW) == DEPTH);
   end

   xmode_e       mode;
   logic [W-1:0] local_word, alu_res, alu_wdata, st_wdata;
   logic         alu_wr, alu_adv, lo_cout, accept, st_we;
   logic         hi_phase, sign_q, carry_q;

   assign mode     = xmode_e'(cfg_mode);
   assign st_we    = erase_busy || (accept && alu_wr);
   assign st_wdata = erase_busy ? '0 : alu_wdata;

   rx_alu #(.W(W)) u_alu (
      .mode(mode), .single(cfg_single), .destr(cfg_destr), .hi_phase(hi_phase),
      .sign_q(sign_q), .carry_q(carry_q), .host(host_data), .local_word(local_word),
      .res(alu_res), .wdata(alu_wdata), .wr(alu_wr), .adv(alu_adv), .lo_cout(lo_cout)
   );

   rx_seq #(.W(W), .DEPTH(DEPTH)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode(mode), .single(cfg_single), .restart(restart),
      .erase_go(erase_go), .host_valid(host_valid), .alu_res(alu_res),
      .alu_adv(alu_adv), .lo_cout(lo_cout), .local_sign(local_word[W-1]),
      .accept(accept), .addr(local_addr), .erase_busy(erase_busy),
      .result_valid(result_valid), .result_data(result_data),
      .hi_phase(hi_phase), .sign_q(sign_q), .carry_q(carry_q)
   );

   rx_store #(.W(W), .DEPTH(DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk(clk), .rst_n(rst_n), .we(st_we), .addr(local_addr),
      .wdata(st_wdata), .rdata(local_word)
   );

   assert_erase_writes_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      erase_busy |-> (st_we && st_wdata == '0));
endmodule

// File: tb/sim_rx_expander.sv
module sim_rx_expander;
   localparam int W = 16;
   localparam int DEPTH = 64;
   localparam int AW = $clog2(DEPTH);

   logic clk = 0, rst_n = 0;
   logic [1:0] cfg_mode = 2'b00;
   logic cfg_single = 0, cfg_destr = 0, restart = 0, erase_go = 0, host_valid = 0;
   logic [W-1:0] host_data = '0;
   logic result_valid, erase_busy;
   logic [W-1:0] result_data;
   logic [AW-1:0] local_addr;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rx_expander #(.W(W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_single(cfg_single),
      .cfg_destr(cfg_destr), .restart(restart), .erase_go(erase_go),
      .host_valid(host_valid), .host_data(host_data), .result_valid(result_valid),
      .result_data(result_data), .local_addr(local_addr), .erase_busy(erase_busy)
   );

   // {local word, 32-bit host value}
   localparam logic [47:0] VEC [6] = '{
      {16'h0005, 32'h0000_0003},
      {16'hFFFF, 32'h0000_0000},
      {16'hFFFE, 32'h0001_0001},
      {16'h8000, 32'h0000_8000},
      {16'h7FFF, 32'h0000_FFFF},
      {16'h1234, 32'hFFFF_FFF0}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic word(input logic [W-1:0] h, input logic [W-1:0] exp, input string tag);
      @(negedge clk);
      host_valid = 1; host_data = h;
      @(negedge clk);
      host_valid = 0;
      chk(result_valid === 1'b1, {tag, " valid"}, result_valid, 1);
      chk(result_data === exp, tag, result_data, exp);
      @(negedge clk);
      chk(result_valid === 1'b0, {tag, " one-cycle R2"}, result_valid, 0);
   endtask

   task automatic do_restart();
      @(negedge clk); restart = 1;
      @(negedge clk); restart = 0;
   endtask

   task automatic setm(input logic [1:0] m, input logic s, input logic d);
      @(negedge clk); cfg_mode = m; cfg_single = s; cfg_destr = d;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] href, sum;
      logic [W-1:0] lw;
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(result_valid === 1'b0, "R1 result_valid", result_valid, 0);
      chk(erase_busy === 1'b0, "R1 erase_busy", erase_busy, 0);
      chk(local_addr === '0, "R1 local_addr", local_addr, 0);
      setm(2'b00, 0, 0);
      word(16'h0, 16'h0, "R1 word0 zero");
      word(16'h0, 16'h0, "R1 word1 zero");

      // vector table: double precision accumulate vs 32-bit reference
      foreach (VEC[i]) begin
         lw = VEC[i][47:32];
         href = VEC[i][31:0];
         sum = href + {{16{lw[15]}}, lw};
         setm(2'b01, 0, 1); do_restart();
         word(lw, lw, "R3 load");
         setm(2'b10, 0, 0); do_restart();
         word(href[15:0], sum[15:0], "R7 low half");
         chk(local_addr === 0, "R7 addr held", local_addr, 0);
         word(href[31:16], sum[31:16], "R8 high half");
         chk(local_addr === 1, "R8 addr advanced", local_addr, 1);
         setm(2'b00, 0, 0); do_restart();
         word(16'h0, 16'h0, "R8 local cleared");
      end

      // R4 non-destructive write adds
      setm(2'b01, 0, 1); do_restart();
      word(16'hFFF0, 16'hFFF0, "R3 overwrite");
      setm(2'b01, 0, 0); do_restart();
      word(16'h0025, 16'h0015, "R4 add wraps");
      chk(local_addr === 1, "R4 addr", local_addr, 1);
      // R5 non-destructive read keeps, destructive read clears
      setm(2'b00, 0, 0); do_restart();
      word(16'h1111, 16'h0015, "R5 read keep");
      do_restart();
      word(16'h0, 16'h0015, "R5 still there");
      setm(2'b11, 0, 1); do_restart();
      word(16'h0, 16'h0015, "R5 destructive read");
      setm(2'b00, 0, 0); do_restart();
      word(16'h0, 16'h0, "R5 cleared");

      // R6 single precision truncating, two words, phase held (R9)
      setm(2'b01, 0, 1); do_restart();
      word(16'h7FFF, 16'h7FFF, "R3 load a");
      word(16'hFFFF, 16'hFFFF, "R3 load b");
      setm(2'b10, 1, 0); do_restart();
      word(16'h0002, 16'h8001, "R6 overflow uncorrected");
      chk(local_addr === 1, "R6 addr advance", local_addr, 1);
      word(16'h0001, 16'h0000, "R6 truncated carry");
      chk(local_addr === 2, "R9 phase held addr", local_addr, 2);
      setm(2'b00, 0, 0); do_restart();
      word(16'h0, 16'h0, "R6 cleared a");
      word(16'h0, 16'h0, "R6 cleared b");

      // R9 restart mid-pair resets phase
      setm(2'b01, 0, 1); do_restart();
      word(16'h0003, 16'h0003, "R3 load c");
      setm(2'b10, 0, 0); do_restart();
      word(16'h0001, 16'h0004, "R9 low");
      do_restart();
      word(16'h0002, 16'h0005, "R9 low again after restart");
      chk(local_addr === 0, "R9 addr", local_addr, 0);

      // R10 erase
      setm(2'b01, 0, 1); do_restart();
      word(16'hAAAA, 16'hAAAA, "R3 load d");
      word(16'h5555, 16'h5555, "R3 load e");
      @(negedge clk); erase_go = 1;
      @(negedge clk); erase_go = 0;
      cnt = 0;
      while (erase_busy === 1'b1 && cnt < 200) begin
         cnt++;
         @(negedge clk);
      end
      chk(cnt == DEPTH, "R10 busy cycles", cnt, DEPTH);
      chk(local_addr === 0, "R10 addr wrapped", local_addr, 0);
      setm(2'b00, 0, 0); do_restart();
      word(16'h0, 16'h0, "R10 erased 0");
      word(16'h0, 16'h0, "R10 erased 1");

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule